// File: doc/BRIEF.md
# Special-Operand Bypass for Double-Precision Add/Subtract

This block sits ahead of a double-precision adder/subtractor. It sorts each operand into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. When either operand falls into a class whose sum or difference needs no arithmetic, the block produces the final 64-bit result and the exception flags itself. In that case it raises a bypass strobe so that the downstream datapath result can be discarded.

For a pair of ordinary nonzero finite operands, the bypass strobe stays low and the normal datapath owns the result. The block does no finite addition and no rounding. Inputs are accepted when `in_valid` is high. Outputs appear one clock later, qualified by `out_valid`.

The block applies one fixed decision table with this priority:

1. Denormal trap.
2. NaN operands.
3. Infinities.
4. Zeros.

Top module: `fp_special_bypass`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted input, `out_valid`, `bypass_valid`, `flag_invalid` and `flag_denorm` are 0 and `bypass_result` is 0.
- R2: `out_valid` equals `in_valid` from the previous rising clock edge. Result and flags belong to the operands sampled on that edge.
- R3: With `daz_en`=0, a denormal operand (exponent field 0, fraction nonzero) in either position sets `flag_denorm`=1 and `bypass_valid`=1, with `bypass_result`=0 and `flag_invalid`=0. This takes precedence over every other case, NaN operands included.
- R4: With `daz_en`=1, a denormal operand acts as a zero carrying its own sign bit and never sets `flag_denorm`.
- R5: A quiet NaN operand (exponent all ones, fraction bit 51 set) with no signalling NaN present yields that NaN unchanged, with `flag_invalid`=0.
- R6: A signalling NaN operand (exponent all ones, bit 51 clear, fraction nonzero) yields its value with bit 51 set and the rest of the payload kept, and sets `flag_invalid`=1.
- R7: When both operands are NaN, the NaN from `op_a` (quieted) is returned. `flag_invalid` is 1 if either operand is signalling.
- R8: An infinity combined with a finite operand yields that infinity. An infinite `op_b` has its sign inverted when `sub_sel`=1. No flag is raised.
- R9: Two infinities under effective subtraction yield 0xFFF8000000000000 and set `flag_invalid`. Effective subtraction is `sub_sel` XOR sign(a) XOR sign(b).
- R10: Two infinities under effective addition yield `op_a`, with no flag.
- R11: A zero combined with a nonzero finite operand yields the other operand. A returned `op_b` has its sign inverted when `sub_sel`=1.
- R12: Two zeros yield a zero whose sign is sign(a) AND (sign(b) XOR `sub_sel`).
- R13: Two nonzero finite non-denormal operands give `bypass_valid`=0, `bypass_result`=0 and both flags 0.
- R14: Whenever `out_valid` is 0, `bypass_valid`, `flag_invalid`, `flag_denorm` and `bypass_result` are 0, whatever the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | 64 | First IEEE double operand |
| op_b | input | 64 | Second IEEE double operand |
| sub_sel | input | 1 | 1 = compute a - b, 0 = a + b |
| daz_en | input | 1 | Treat denormal operands as signed zeros |
| out_valid | output | 1 | Registered copy of `in_valid` |
| bypass_valid | output | 1 | Result below is final; normal datapath is bypassed |
| bypass_result | output | 64 | Final result for special cases |
| flag_invalid | output | 1 | Invalid-operation exception |
| flag_denorm | output | 1 | Denormal-input trap |

## Verification
The bench targets the ordering between cases. A denormal beside a NaN must trap rather than propagate. With two NaNs the first must win even when only the second is signalling, and a design that picked the signalling one would return the wrong payload. Sign handling under subtraction is probed through infinities and zeros, where a design that ignored `sub_sel` on `op_b` would report +inf for 1 - inf or give +0 for -0 - 0. The bench also checks that same-direction infinities are not mistaken for a cancelling pair, and that flags cannot leak onto idle cycles.

// File: rtl/fp_special_bypass.sv
module fp_special_bypass #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [EXP_W+FRAC_W:0]       op_a,
  input  logic [EXP_W+FRAC_W:0]       op_b,
  input  logic                        sub_sel,
  input  logic                        daz_en,
  output logic                        out_valid,
  output logic                        bypass_valid,
  output logic [EXP_W+FRAC_W:0]       bypass_result,
  output logic                        flag_invalid,
  output logic                        flag_denorm
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT  = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] CQNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_s, b_s, b_es, eff_sub;
  logic [EXP_W-1:0]  a_e, b_e;
  logic [FRAC_W-1:0] a_f, b_f;

  assign a_s = op_a[W-1];
  assign b_s = op_b[W-1];
  assign a_e = op_a[W-2:FRAC_W];
  assign b_e = op_b[W-2:FRAC_W];
  assign a_f = op_a[FRAC_W-1:0];
  assign b_f = op_b[FRAC_W-1:0];
  assign b_es    = b_s ^ sub_sel;
  assign eff_sub = a_s ^ b_es;

  logic a_nan, a_snan, a_inf, a_den, a_zero;
  logic b_nan, b_snan, b_inf, b_den, b_zero;

  assign a_nan  = (&a_e) & (|a_f);
  assign a_snan = a_nan & ~a_f[FRAC_W-1];
  assign a_inf  = (&a_e) & ~(|a_f);
  assign a_den  = ~(|a_e) & (|a_f);
  assign a_zero = ~(|a_e) & (~(|a_f) | daz_en);

  assign b_nan  = (&b_e) & (|b_f);
  assign b_snan = b_nan & ~b_f[FRAC_W-1];
  assign b_inf  = (&b_e) & ~(|b_f);
  assign b_den  = ~(|b_e) & (|b_f);
  assign b_zero = ~(|b_e) & (~(|b_f) | daz_en);

  logic           n_byp, n_inv, n_den;
  logic [W-1:0]   n_res;

  always_comb begin
    n_byp = 1'b1;
    n_inv = 1'b0;
    n_den = 1'b0;
    n_res = '0;
    if (!daz_en && (a_den || b_den)) begin
      n_den = 1'b1;
    end else if (a_nan || b_nan) begin
      n_res = a_nan ? (op_a | QBIT) : (op_b | QBIT);
      n_inv = a_snan | b_snan;
    end else if (a_inf && b_inf) begin
      if (eff_sub) begin
        n_res = CQNAN;
        n_inv = 1'b1;
      end else begin
        n_res = op_a;
      end
    end else if (a_inf) begin
      n_res = op_a;
    end else if (b_inf) begin
      n_res = {b_es, op_b[W-2:0]};
    end else if (a_zero && b_zero) begin
      n_res = {a_s & b_es, {(W-1){1'b0}}};
    end else if (a_zero) begin
      n_res = {b_es, op_b[W-2:0]};
    end else if (b_zero) begin
      n_res = op_a;
    end else begin
      n_byp = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      bypass_valid  <= 1'b0;
      bypass_result <= '0;
      flag_invalid  <= 1'b0;
      flag_denorm   <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      bypass_valid  <= in_valid & n_byp;
      bypass_result <= in_valid ? n_res : '0;
      flag_invalid  <= in_valid & n_inv;
      flag_denorm   <= in_valid & n_den;
    end
  end
endmodule

// File: rtl/fp_special_bypass_chk.sv
module fp_special_bypass_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  daz_en,
  input logic                  out_valid,
  input logic                  bypass_valid,
  input logic [EXP_W+FRAC_W:0] bypass_result,
  input logic                  flag_invalid,
  input logic                  flag_denorm
);
  localparam int W = 1 + EXP_W + FRAC_W;

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!bypass_valid && !flag_invalid && !flag_denorm && bypass_result == '0));
  p_trap_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_denorm |-> (bypass_valid && !flag_invalid && bypass_result == '0));
  p_no_trap_daz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && daz_en) |=> !flag_denorm);
  p_invalid_gives_qnan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |-> (bypass_valid && (&bypass_result[W-2:FRAC_W]) && bypass_result[FRAC_W-1]));
  p_nan_out_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_valid && (&bypass_result[W-2:FRAC_W]) && (|bypass_result[FRAC_W-1:0]))
      |-> bypass_result[FRAC_W-1]);
  p_no_byp_no_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_valid |-> (!flag_invalid && !flag_denorm));
endmodule

bind fp_special_bypass fp_special_bypass_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .daz_en(daz_en),
  .out_valid(out_valid), .bypass_valid(bypass_valid), .bypass_result(bypass_result),
  .flag_invalid(flag_invalid), .flag_denorm(flag_denorm));

// File: tb/fp_special_bypass_tb.sv
module fp_special_bypass_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [63:0] ONE   = 64'h3FF0000000000000;
  localparam logic [63:0] TWO   = 64'h4000000000000000;
  localparam logic [63:0] MTWO  = 64'hC000000000000000;
  localparam logic [63:0] PINF  = 64'h7FF0000000000000;
  localparam logic [63:0] NINF  = 64'hFFF0000000000000;
  localparam logic [63:0] QN    = 64'h7FF8000000000123;
  localparam logic [63:0] SN    = 64'h7FF0000000000456;
  localparam logic [63:0] SNQ   = 64'h7FF8000000000456;
  localparam logic [63:0] DEN   = 64'h0000000000000001;
  localparam logic [63:0] NDEN  = 64'h8000000000000005;
  localparam logic [63:0] PZ    = 64'h0;
  localparam logic [63:0] NZ    = 64'h8000000000000000;
  localparam logic [63:0] CQ    = 64'hFFF8000000000000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic sub_sel = 1'b0, daz_en = 1'b0;
  logic out_valid, bypass_valid, flag_invalid, flag_denorm;
  logic [63:0] bypass_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_special_bypass dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .daz_en(daz_en), .out_valid(out_valid),
    .bypass_valid(bypass_valid), .bypass_result(bypass_result),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm));

  task automatic check(input string req, input logic ev, input logic eb,
                       input logic [63:0] er, input logic ei, input logic ed);
    checks++;
    if (out_valid !== ev || bypass_valid !== eb || bypass_result !== er ||
        flag_invalid !== ei || flag_denorm !== ed) begin
      errors++;
      $display("FAIL %s: got v=%b b=%b r=%h i=%b d=%b, expected v=%b b=%b r=%h i=%b d=%b",
               req, out_valid, bypass_valid, bypass_result, flag_invalid, flag_denorm,
               ev, eb, er, ei, ed);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic s, input logic z);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = s; daz_en = z; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset", 0, 0, 64'h0, 0, 0);
  endtask

  task automatic t_latency;
    apply(ONE, SN, 0, 0);
    check("R2 one-cycle result", 1, 1, SNQ, 1, 0);
    @(negedge clk);
    check("R14 idle cycle quiet", 0, 0, 64'h0, 0, 0);
  endtask

  task automatic t_denorm_trap;
    apply(QN, DEN, 0, 0);
    check("R3 denormal beats qnan", 1, 1, 64'h0, 0, 1);
    apply(SN, NDEN, 1, 0);
    check("R3 denormal beats snan", 1, 1, 64'h0, 0, 1);
    apply(DEN, ONE, 0, 0);
    check("R3 denormal op_a", 1, 1, 64'h0, 0, 1);
  endtask

  task automatic t_daz;
    apply(NDEN, ONE, 0, 1);
    check("R4 daz denormal a as zero", 1, 1, ONE, 0, 0);
    apply(ONE, DEN, 1, 1);
    check("R4 daz denormal b as zero", 1, 1, ONE, 0, 0);
    apply(NDEN, NZ, 0, 1);
    check("R4 daz signed zero sum", 1, 1, NZ, 0, 0);
  endtask

  task automatic t_nans;
    apply(QN, ONE, 0, 0);
    check("R5 qnan passes", 1, 1, QN, 0, 0);
    apply(ONE, SN, 1, 0);
    check("R6 snan quieted", 1, 1, SNQ, 1, 0);
    apply(QN, SN, 0, 0);
    check("R7 first nan wins", 1, 1, QN, 1, 0);
    apply(SN, QN, 0, 0);
    check("R7 first snan quieted", 1, 1, SNQ, 1, 0);
  endtask

  task automatic t_infs;
    apply(PINF, ONE, 0, 0);
    check("R8 inf plus finite", 1, 1, PINF, 0, 0);
    apply(ONE, PINF, 1, 0);
    check("R8 finite minus inf", 1, 1, NINF, 0, 0);
    apply(NINF, TWO, 1, 0);
    check("R8 neg inf minus finite", 1, 1, NINF, 0, 0);
    apply(PINF, PINF, 1, 0);
    check("R9 inf minus inf", 1, 1, CQ, 1, 0);
    apply(PINF, NINF, 0, 0);
    check("R9 inf plus neg inf", 1, 1, CQ, 1, 0);
    apply(NINF, NINF, 0, 0);
    check("R10 same-sign infs", 1, 1, NINF, 0, 0);
    apply(PINF, NINF, 1, 0);
    check("R10 inf minus neg inf", 1, 1, PINF, 0, 0);
  endtask

  task automatic t_zeros;
    apply(PZ, TWO, 0, 0);
    check("R11 zero plus x", 1, 1, TWO, 0, 0);
    apply(PZ, TWO, 1, 0);
    check("R11 zero minus x", 1, 1, MTWO, 0, 0);
    apply(TWO, NZ, 1, 0);
    check("R11 x minus zero", 1, 1, TWO, 0, 0);
    apply(PZ, PZ, 0, 0);
    check("R12 +0 + +0", 1, 1, PZ, 0, 0);
    apply(NZ, NZ, 0, 0);
    check("R12 -0 + -0", 1, 1, NZ, 0, 0);
    apply(NZ, PZ, 1, 0);
    check("R12 -0 - +0", 1, 1, NZ, 0, 0);
    apply(PZ, PZ, 1, 0);
    check("R12 +0 - +0", 1, 1, PZ, 0, 0);
  endtask

  task automatic t_normal;
    apply(ONE, TWO, 0, 0);
    check("R13 ordinary operands", 1, 0, 64'h0, 0, 0);
    apply(ONE, MTWO, 1, 1);
    check("R13 ordinary with daz", 1, 0, 64'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latency;
    t_denorm_trap;
    t_daz;
    t_nans;
    t_infs;
    t_zeros;
    t_normal;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule